// File: doc/BRIEF.md
# Flagged 32-bit ALU

This block is the arithmetic and logic unit of a small load-store core. A 4-bit operation code selects one of fifteen operations on two 32-bit operands. The result and a result-write strobe come out combinationally in the same cycle. The four condition flags (carry, sign, overflow, zero) are captured in a register on the next clock edge. The core supplies its current carry flag on `carry_i` for the operations that consume a carry. It drives `en_i` high in the cycles in which it issues an ALU operation.

The comparison operation updates only the flags. Invert, increment and decrement read operand 1 alone. The code 1111 is not assigned and has no effect. When no operation is issued, the flags hold their value.

Top module: `flagged_alu`

## Requirements
- R1: Codes 0000 add, 0001 add-with-carry, 0010 subtract and 0011 subtract-with-carry give a+b, a+b+carry_i, a−b and a−(b+carry_i), each modulo 2^32.
- R2: Code 0100 gives the low 32 bits of a×b. Code 0101 gives the low 32 bits of a×b+carry_i. Both leave the carry flag unchanged and clear the overflow flag.
- R3: Codes 0110 and, 0111 or, 1000 xor and 1011 invert give the bitwise result. Invert ignores b. All four leave the carry flag unchanged and clear the overflow flag.
- R4: Codes 1001 (left shift) and 1010 (logical right shift) shift a by b[4:0]. The carry flag takes the last bit shifted out. A shift by zero leaves the carry flag unchanged. Overflow is cleared.
- R5: Codes 1101 (increment) and 1110 (decrement) give a+1 and a−1 and ignore b. Carry is the carry-out or the borrow, and overflow is the signed overflow of the step.
- R6: Code 1100 (compare) sets every flag as subtract does. Its write strobe stays low.
- R7: Code 1111 drives result 0, keeps the write strobe low and changes no flag.
- R8: For additions the carry flag is the carry-out of bit 31. For subtractions it is the borrow. Overflow is set when the exact signed result does not fit in 32 bits.
- R9: On every flag update, zero is set exactly when the 32-bit result is 0, and sign is result bit 31.
- R10: The flags change only on the clock edge that ends a cycle with en_i high and a valid code. With en_i low the write strobe is low. Reset clears all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Operation issued this cycle |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand 1 |
| b_i | input | 32 | Operand 2 |
| carry_i | input | 1 | Current carry flag from the core |
| result_o | output | 32 | Combinational result |
| wr_o | output | 1 | Result-write strobe |
| carry_o | output | 1 | Registered carry flag |
| sign_o | output | 1 | Registered sign flag |
| ovf_o | output | 1 | Registered overflow flag |
| zero_o | output | 1 | Registered zero flag |

## Verification
The only state in the block is the flag register. A wrong kept carry shows on `carry_o` one edge after the operation that should have preserved it. It shows again on the result of the next add-with-carry, if the core feeds it back. A wrong update enable shows as flags that move during idle cycles or on code 1111. It is seen at the first such edge. Result and strobe faults have no delay: they appear in the same cycle the code is applied. The reference model is therefore compared on every issue and one edge later.

// File: rtl/flagged_alu_pkg.sv
package flagged_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'b0000,
        OP_ADDC = 4'b0001,
        OP_SUB  = 4'b0010,
        OP_SUBC = 4'b0011,
        OP_MUL  = 4'b0100,
        OP_MULC = 4'b0101,
        OP_AND  = 4'b0110,
        OP_OR   = 4'b0111,
        OP_XOR  = 4'b1000,
        OP_SHL  = 4'b1001,
        OP_SHR  = 4'b1010,
        OP_INV  = 4'b1011,
        OP_CMP  = 4'b1100,
        OP_INC  = 4'b1101,
        OP_DEC  = 4'b1110,
        OP_NONE = 4'b1111
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic sign;
        logic ovf;
        logic zero;
    } alu_flags_t;

    function automatic logic is_arith(alu_op_e op);
        return (op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_MUL,
                           OP_MULC, OP_CMP, OP_INC, OP_DEC});
    endfunction

endpackage

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import flagged_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout,
    output logic           cupd,
    output logic           ovf
);
    localparam int EW = W + 2;

    logic           sub_mode;
    logic           extra;
    logic [W-1:0]   rhs;
    logic [W:0]     sum_u, dif_u;
    logic [EW-1:0]  sum_s, dif_s, exact;
    logic [W-1:0]   prod;

    always_comb begin
        sub_mode = 1'b0;
        extra    = 1'b0;
        rhs      = b;
        unique case (op)
            OP_ADDC: extra = cin;
            OP_SUB,
            OP_CMP:  sub_mode = 1'b1;
            OP_SUBC: begin sub_mode = 1'b1; extra = cin; end
            OP_INC:  rhs = W'(1);
            OP_DEC:  begin sub_mode = 1'b1; rhs = W'(1); end
            default: ;
        endcase
    end

    assign sum_u = {1'b0, a} + {1'b0, rhs} + {{W{1'b0}}, extra};
    assign dif_u = {1'b0, a} - {1'b0, rhs} - {{W{1'b0}}, extra};
    assign sum_s = {{2{a[W-1]}}, a} + {{2{rhs[W-1]}}, rhs} + {{(EW-1){1'b0}}, extra};
    assign dif_s = {{2{a[W-1]}}, a} - {{2{rhs[W-1]}}, rhs} - {{(EW-1){1'b0}}, extra};
    assign exact = sub_mode ? dif_s : sum_s;
    assign prod  = (a * b) + {{(W-1){1'b0}}, (op == OP_MULC) ? cin : 1'b0};

    always_comb begin
        if (op == OP_MUL || op == OP_MULC) begin
            res  = prod;
            cout = 1'b0;
            cupd = 1'b0;
            ovf  = 1'b0;
        end else begin
            res  = sub_mode ? dif_u[W-1:0] : sum_u[W-1:0];
            cout = sub_mode ? dif_u[W] : sum_u[W];
            cupd = 1'b1;
            ovf  = !((exact[EW-1] == exact[EW-2]) && (exact[EW-2] == exact[EW-3]));
        end
    end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import flagged_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           cout,
    output logic           cupd
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] amt;
    logic [W:0]    shl_w;
    logic [W:0]    shr_w;

    assign amt   = b[SW-1:0];
    assign shl_w = {1'b0, a} << amt;
    assign shr_w = {a, 1'b0} >> amt;

    always_comb begin
        res  = '0;
        cout = 1'b0;
        cupd = 1'b0;
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_INV: res = ~a;
            OP_SHL: begin
                res  = shl_w[W-1:0];
                cout = shl_w[W];
                cupd = (amt != '0);
            end
            OP_SHR: begin
                res  = shr_w[W:1];
                cout = shr_w[0];
                cupd = (amt != '0);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import flagged_alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  alu_flags_t  next_flags,
    output alu_flags_t  flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags <= '0;
        else if (load)
            flags <= next_flags;
    end
endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
    import flagged_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [3:0]    op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          carry_i,
    output logic [W-1:0]  result_o,
    output logic          wr_o,
    output logic          carry_o,
    output logic          sign_o,
    output logic          ovf_o,
    output logic          zero_o
);
    alu_op_e     op;
    logic [W-1:0] ar_res, lg_res;
    logic        ar_cout, ar_cupd, ar_ovf;
    logic        lg_cout, lg_cupd;
    logic        use_arith, op_valid;
    logic        new_carry, new_ovf, carry_upd;
    alu_flags_t  nxt, cur;

    assign op = alu_op_e'(op_i);

    alu_arith_unit #(.W(W)) u_arith (
        .op(op), .a(a_i), .b(b_i), .cin(carry_i),
        .res(ar_res), .cout(ar_cout), .cupd(ar_cupd), .ovf(ar_ovf)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .op(op), .a(a_i), .b(b_i),
        .res(lg_res), .cout(lg_cout), .cupd(lg_cupd)
    );

    assign use_arith = is_arith(op);
    assign op_valid  = (op != OP_NONE);

    always_comb begin
        if (!op_valid)
            result_o = '0;
        else if (use_arith)
            result_o = ar_res;
        else
            result_o = lg_res;
    end

    assign new_carry = use_arith ? ar_cout : lg_cout;
    assign carry_upd = use_arith ? ar_cupd : lg_cupd;
    assign new_ovf   = use_arith ? ar_ovf  : 1'b0;

    always_comb begin
        nxt.carry = carry_upd ? new_carry : cur.carry;
        nxt.sign  = result_o[W-1];
        nxt.ovf   = new_ovf;
        nxt.zero  = (result_o == '0);
    end

    assign wr_o = en_i && op_valid && (op != OP_CMP);

    alu_flag_reg u_flags (
        .clk(clk), .rst_n(rst_n), .load(en_i && op_valid),
        .next_flags(nxt), .flags(cur)
    );

    assign carry_o = cur.carry;
    assign sign_o  = cur.sign;
    assign ovf_o   = cur.ovf;
    assign zero_o  = cur.zero;

endmodule

// File: rtl/flagged_alu_chk.sv
module flagged_alu_chk #(
    parameter int W = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_i,
    input logic [3:0]    op_i,
    input logic [W-1:0]  a_i,
    input logic [W-1:0]  result_o,
    input logic          wr_o,
    input logic          carry_o,
    input logic          sign_o,
    input logic          ovf_o,
    input logic          zero_o
);
    // R6
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == 4'b1100) |-> !wr_o);

    // R7
    unused_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'b1111) |=> ($stable(carry_o) && $stable(sign_o) && $stable(ovf_o) && $stable(zero_o)));

    // R10
    idle_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(carry_o) && $stable(sign_o) && $stable(ovf_o) && $stable(zero_o) && !$past(wr_o)));

    // R3
    logic_carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (op_i inside {4'b0110, 4'b0111, 4'b1000, 4'b1011})) |=> ($stable(carry_o) && !ovf_o));

    // R3
    invert_ignores_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'b1011) |-> (result_o == ~a_i));

    // R9
    zero_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i != 4'b1111) |=> (zero_o == ($past(result_o) == '0) && sign_o == $past(result_o[W-1])));
endmodule

bind flagged_alu flagged_alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .a_i(a_i),
    .result_o(result_o), .wr_o(wr_o), .carry_o(carry_o), .sign_o(sign_o),
    .ovf_o(ovf_o), .zero_o(zero_o)
);

// File: tb/tb_flagged_alu.sv
module tb_flagged_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [3:0]  op_i = 4'b0;
    logic [31:0] a_i = '0, b_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        wr_o, carry_o, sign_o, ovf_o, zero_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model flag state {carry, sign, ovf, zero}
    bit mc = 0, ms = 0, mv = 0, mz = 0;

    always #10 clk = ~clk;  // 50 MHz

    flagged_alu dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .carry_i(carry_i), .result_o(result_o), .wr_o(wr_o), .carry_o(carry_o),
        .sign_o(sign_o), .ovf_o(ovf_o), .zero_o(zero_o)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3: return "R1";
            4'd4, 4'd5:             return "R2";
            4'd6, 4'd7, 4'd8, 4'd11: return "R3";
            4'd9, 4'd10:            return "R4";
            4'd12:                  return "R6";
            4'd13, 4'd14:           return "R5";
            default:                return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit sfits(input longint x);
        return (x <= 64'sd2147483647) && (x >= -64'sd2147483648);
    endfunction

    task automatic check_flags(input string req);
        check(req, "carry flag", carry_o, mc);
        check("R9", "sign flag", sign_o, ms);
        check(req, "overflow flag", ovf_o, mv);
        check("R9", "zero flag", zero_o, mz);
    endtask

    task automatic step(input bit en, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input bit cin);
        longint unsigned A, B, full;
        longint sa, sb;
        logic [31:0] r;
        bit c, v;
        int s;
        @(negedge clk);
        check_flags("R10");
        en_i = en; op_i = op; a_i = a; b_i = b; carry_i = cin;
        A = a; B = b; sa = longint'($signed(a)); sb = longint'($signed(b));
        s = int'(b[4:0]);
        c = mc; v = 0; r = 0;
        case (op)
            4'd0: begin full = A + B; r = full[31:0]; c = full[32]; v = !sfits(sa + sb); end
            4'd1: begin full = A + B + cin; r = full[31:0]; c = full[32]; v = !sfits(sa + sb + cin); end
            4'd2, 4'd12: begin r = 32'(A - B); c = A < B; v = !sfits(sa - sb); end
            4'd3: begin r = 32'(A - B - cin); c = A < (B + cin); v = !sfits(sa - sb - cin); end
            4'd4: r = 32'(A * B);
            4'd5: r = 32'(A * B + cin);
            4'd6: r = a & b;
            4'd7: r = a | b;
            4'd8: r = a ^ b;
            4'd11: r = ~a;
            4'd9: begin r = 32'(A << s); if (s != 0) c = ((A >> (32 - s)) & 1) != 0; end
            4'd10: begin r = 32'(A >> s); if (s != 0) c = ((A >> (s - 1)) & 1) != 0; end
            4'd13: begin r = 32'(A + 1); c = (a == 32'hFFFF_FFFF); v = (a == 32'h7FFF_FFFF); end
            4'd14: begin r = 32'(A - 1); c = (a == 0); v = (a == 32'h8000_0000); end
            default: r = 0;
        endcase
        #2;
        check(req_of(op), "result", result_o, r);
        check(en ? req_of(op) : "R10", "write strobe", wr_o, en && op != 4'd15 && op != 4'd12);
        if (en && op != 4'd15) begin
            mc = c; mv = v; ms = r[31]; mz = (r == 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset clears flags
        check_flags("R10");
        rst_n = 1'b1;
        // R1 / R8
        step(1, 4'd0, 32'hFFFF_FFFF, 32'h1, 0);
        step(1, 4'd0, 32'h7FFF_FFFF, 32'h1, 0);
        step(1, 4'd1, 32'h0000_0010, 32'h0000_0020, 1);
        step(1, 4'd2, 32'h5, 32'h7, 0);
        step(1, 4'd2, 32'h8000_0000, 32'h1, 0);
        step(1, 4'd3, 32'h5, 32'h5, 1);
        step(1, 4'd3, 32'h0, 32'hFFFF_FFFF, 1);
        // R2
        step(1, 4'd4, 32'h0001_0000, 32'h0001_0003, 0);
        step(1, 4'd5, 32'hFFFF_FFFF, 32'h1, 1);
        // R3 carry kept from previous
        step(1, 4'd2, 32'h0, 32'h1, 0);
        step(1, 4'd6, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 0);
        step(1, 4'd7, 32'h1200_0000, 32'h0000_0034, 0);
        step(1, 4'd8, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0);
        step(1, 4'd11, 32'h0, 32'h1234_5678, 1);
        // R4
        step(1, 4'd9, 32'h8000_0001, 32'd1, 0);
        step(1, 4'd9, 32'h0000_0003, 32'hFFFF_FFE0, 0);
        step(1, 4'd10, 32'h0000_0003, 32'd1, 0);
        step(1, 4'd10, 32'h8000_0000, 32'd31, 0);
        // R5
        step(1, 4'd13, 32'hFFFF_FFFF, 32'h55, 0);
        step(1, 4'd13, 32'h7FFF_FFFF, 32'h0, 1);
        step(1, 4'd14, 32'h0, 32'h9, 0);
        step(1, 4'd14, 32'h8000_0000, 32'h0, 0);
        // R6
        step(1, 4'd12, 32'h3, 32'h3, 0);
        step(1, 4'd12, 32'h1, 32'h2, 0);
        // R7
        step(1, 4'd15, 32'h0, 32'h0, 1);
        step(1, 4'd15, 32'h1234, 32'h1234, 0);
        // R10 idle
        step(0, 4'd0, 32'h0, 32'h0, 0);
        step(0, 4'd2, 32'h1, 32'h5, 1);
        for (int i = 0; i < 400; i++)
            step(($urandom % 8) != 0, 4'($urandom), $urandom, $urandom, 1'($urandom));
        @(negedge clk);
        check_flags("R10");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule